// File: doc/BRIEF.md
# Multi-Polynomial CRC Accelerator

This block updates a running CRC remainder with one 32-bit data word per command, for a 32-bit packet-processing datapath. A mode input picks one of five generator polynomials: CRC-32, the CRC-32C polynomial used by iSCSI, CRC-16, and the two short ATM checks, CRC-10 and CRC-5. All five share one remainder register. A narrow CRC uses the low-order bits of that register, and the bits above its width are always zero.

Software seeds the remainder by writing it, and reads the result from the remainder output. It can also save the remainder and later write it back, so that several streams can share the engine. Each command carries a byte count, so the last word of a message can feed one, two, three or four bytes. The bytes are taken from the most significant end of the word, and the first byte fed is the most significant one. Bits go in MSB first, with no reflection and no final XOR.

A start strobe captures the command. The remainder is updated one clock edge later, and a one-cycle done pulse appears together with the new remainder. Commands may be issued on consecutive cycles.

Top module: `crc_accel`

## Requirements
- R1: After reset, `rem_out` is 0 and `done` is 0.
- R2: When `wr_en` is high at a clock edge, the remainder takes `wr_data` masked to the width of the mode on `mode`, and `rem_out` shows it after that edge.
- R3: Mode code 0 is CRC-32 with polynomial 0x04C11DB7. From seed 0xFFFFFFFF, the ASCII bytes "123456789" give 0x0376E6E7.
- R4: Mode code 1 is CRC-32C with polynomial 0x1EDC6F41 and a 32-bit remainder.
- R5: Mode code 2 is CRC-16 with polynomial 0x8005. From seed 0, the ASCII bytes "123456789" give 0xFEE8, and bits 31..16 of `rem_out` read 0.
- R6: Mode code 3 is CRC-10 with polynomial 0x233. Mode code 4 is CRC-5 with polynomial 0x05. Each keeps its remainder in bits 9..0 or 4..0, and the bits above read 0.
- R7: `nbytes` values 1, 2 and 3 feed that many bytes, taken from bits 31..24 downward and most significant byte first. The value 0 feeds all four bytes.
- R8: A `start` sampled at edge E makes `done` high for exactly one cycle after edge E+1, and the updated remainder appears on `rem_out` at that same edge. The update processes each bit as follows: feedback = remainder MSB XOR data bit; shift the remainder left within its width; XOR in the polynomial when feedback is 1.
- R9: With no command completing and no write, the remainder does not change.
- R10: Starts on consecutive cycles are each applied in order. The second one uses the remainder produced by the first.
- R11: If a write and a completing update fall on the same edge, the write value is stored and `done` still pulses.
- R12: Mode codes 5, 6 and 7 behave as CRC-32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe; captures data, byte count and mode |
| mode | input | 3 | Polynomial select for a command or a write |
| data | input | 32 | Data word for the command |
| nbytes | input | 2 | Bytes to feed; 0 means four |
| wr_en | input | 1 | Remainder write strobe |
| wr_data | input | 32 | Remainder value to write |
| rem_out | output | 32 | Current remainder |
| done | output | 1 | One-cycle pulse when an update lands |

## Verification
The assertions take for granted that `mode` is stable while `wr_en` or `start` is high, and that `start` and `wr_en` are clean single-cycle strobes sampled on the clock. The upper-zero checks also assume that the mode given at a write matches the width the write is meant for. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. It draws random seeds, words, counts and all eight mode codes, and masks each seed to the selected width. The directed cases cover back-to-back commands and a write that lands on the same edge as an update.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned WID_W  = 6;

  localparam logic [2:0] SEL_C32  = 3'd0;
  localparam logic [2:0] SEL_C32C = 3'd1;
  localparam logic [2:0] SEL_C16  = 3'd2;
  localparam logic [2:0] SEL_C10  = 3'd3;
  localparam logic [2:0] SEL_C5   = 3'd4;

  function automatic logic [WORD_W-1:0] sel_poly(input logic [2:0] sel);
    case (sel)
      SEL_C32C: sel_poly = 32'h1EDC6F41;
      SEL_C16:  sel_poly = 32'h00008005;
      SEL_C10:  sel_poly = 32'h00000233;
      SEL_C5:   sel_poly = 32'h00000005;
      default:  sel_poly = 32'h04C11DB7;
    endcase
  endfunction

  function automatic logic [WID_W-1:0] sel_width(input logic [2:0] sel);
    case (sel)
      SEL_C16: sel_width = 6'd16;
      SEL_C10: sel_width = 6'd10;
      SEL_C5:  sel_width = 6'd5;
      default: sel_width = 6'd32;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] width_mask(input logic [WID_W-1:0] w);
    if (w >= WID_W'(WORD_W)) width_mask = '1;
    else                     width_mask = (WORD_W'(1) << w) - WORD_W'(1);
  endfunction
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step
  import crc_pkg::*;
#(
  parameter int unsigned REM_W = 32
) (
  input  logic [REM_W-1:0] rem_i,
  input  logic [7:0]       byte_i,
  input  logic [REM_W-1:0] poly_i,
  input  logic [WID_W-1:0] width_i,
  output logic [REM_W-1:0] rem_o
);
  logic [REM_W-1:0] msk;
  logic [REM_W-1:0] acc;
  logic             fb;

  always_comb begin
    msk = width_mask(width_i);
    acc = rem_i;
    fb  = 1'b0;
    for (int b = 7; b >= 0; b--) begin
      fb  = acc[width_i - WID_W'(1)] ^ byte_i[b];
      acc = (acc << 1) & msk;
      if (fb) acc = acc ^ poly_i;
    end
    rem_o = acc;
  end
endmodule

// File: rtl/crc_word_dp.sv
module crc_word_dp
  import crc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REM_W  = 32,
  localparam int unsigned NB    = DATA_W / 8,
  localparam int unsigned NBC_W = $clog2(NB),
  localparam int unsigned CNT_W = $clog2(NB + 1)
) (
  input  logic [REM_W-1:0]  rem_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [NBC_W-1:0]  nbytes_i,
  input  logic [REM_W-1:0]  poly_i,
  input  logic [WID_W-1:0]  width_i,
  output logic [REM_W-1:0]  rem_o
);
  logic [REM_W-1:0] stage [0:NB];
  logic [CNT_W-1:0] used;

  assign stage[0] = rem_i;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    crc_byte_step #(.REM_W(REM_W)) u_step (
      .rem_i  (stage[k]),
      .byte_i (data_i[DATA_W-1-8*k -: 8]),
      .poly_i (poly_i),
      .width_i(width_i),
      .rem_o  (stage[k+1])
    );
  end

  always_comb begin
    used = (nbytes_i == '0) ? CNT_W'(NB) : CNT_W'(nbytes_i);
    rem_o = stage[NB];
    for (int k = 1; k <= NB; k++)
      if (used == CNT_W'(k)) rem_o = stage[k];
  end

  always_comb begin
    assert_count_range_R7: assert (used >= CNT_W'(1) && used <= CNT_W'(NB));
  end
endmodule

// File: rtl/crc_accel.sv
module crc_accel
  import crc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REM_W  = 32,
  localparam int unsigned NBC_W = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [DATA_W-1:0] data,
  input  logic [NBC_W-1:0]  nbytes,
  input  logic              wr_en,
  input  logic [REM_W-1:0]  wr_data,
  output logic [REM_W-1:0]  rem_out,
  output logic              done
);
  logic              cmd_v_q,  cmd_v_d;
  logic [DATA_W-1:0] cmd_dat_q, cmd_dat_d;
  logic [NBC_W-1:0]  cmd_cnt_q, cmd_cnt_d;
  logic [2:0]        cmd_sel_q, cmd_sel_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic              done_q, done_d;
  logic              cmd_en, rem_en;
  logic [REM_W-1:0]  upd_rem;

  crc_word_dp #(.DATA_W(DATA_W), .REM_W(REM_W)) u_dp (
    .rem_i   (rem_q),
    .data_i  (cmd_dat_q),
    .nbytes_i(cmd_cnt_q),
    .poly_i  (REM_W'(sel_poly(cmd_sel_q))),
    .width_i (sel_width(cmd_sel_q)),
    .rem_o   (upd_rem)
  );

  always_comb begin
    cmd_en    = start;
    cmd_v_d   = start;
    cmd_dat_d = data;
    cmd_cnt_d = nbytes;
    cmd_sel_d = mode;
    rem_en    = wr_en | cmd_v_q;
    if (wr_en) rem_d = wr_data & REM_W'(width_mask(sel_width(mode)));
    else       rem_d = upd_rem;
    done_d    = cmd_v_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_v_q   <= 1'b0;
      cmd_dat_q <= '0;
      cmd_cnt_q <= '0;
      cmd_sel_q <= '0;
      rem_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      cmd_v_q <= cmd_v_d;
      done_q  <= done_d;
      if (cmd_en) begin
        cmd_dat_q <= cmd_dat_d;
        cmd_cnt_q <= cmd_cnt_d;
        cmd_sel_q <= cmd_sel_d;
      end
      if (rem_en) rem_q <= rem_d;
    end
  end

  assign rem_out = rem_q;
  assign done    = done_q;

  assert_done_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ##1 done);
  assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 2));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !cmd_v_q) |=> $stable(rem_out));
  assert_upd_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_v_q && !wr_en) |=>
      ((rem_out & ~REM_W'(width_mask(sel_width($past(cmd_sel_q))))) == '0));
  assert_wr_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rem_out == ($past(wr_data) & REM_W'(width_mask(sel_width($past(mode)))))));
  assert_collision_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd_v_q) |=> done);
endmodule

// File: tb/crc_accel_test.sv
module crc_accel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [31:0] data = '0;
  logic [1:0]  nbytes = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rem_out;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  crc_accel uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .data(data),
    .nbytes(nbytes), .wr_en(wr_en), .wr_data(wr_data),
    .rem_out(rem_out), .done(done)
  );

  function automatic int tb_width(input logic [2:0] m);
    case (m)
      3'd2: return 16;
      3'd3: return 10;
      3'd4: return 5;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] tb_poly(input logic [2:0] m);
    case (m)
      3'd1: return 32'h1EDC6F41;
      3'd2: return 32'h8005;
      3'd3: return 32'h233;
      3'd4: return 32'h05;
      default: return 32'h04C11DB7;
    endcase
  endfunction

  function automatic logic [31:0] tb_mask(input logic [2:0] m);
    int w = tb_width(m);
    return (w == 32) ? 32'hFFFFFFFF : ((32'd1 << w) - 32'd1);
  endfunction

  function automatic logic [31:0] ref_crc(input logic [31:0] r, input logic [31:0] d,
                                          input logic [1:0] nb, input logic [2:0] m);
    int w = tb_width(m);
    int bits = (nb == 2'd0) ? 32 : 8 * int'(nb);
    logic [31:0] acc = r & tb_mask(m);
    for (int i = 0; i < bits; i++) begin
      logic fb;
      fb = acc[w-1] ^ d[31-i];
      acc = (acc << 1) & tb_mask(m);
      if (fb) acc = acc ^ tb_poly(m);
    end
    return acc;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic seed(input logic [2:0] m, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v; mode = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input logic [2:0] m, input logic [31:0] d, input logic [1:0] nb);
    @(negedge clk);
    start = 1'b1; mode = m; data = d; nbytes = nb;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  logic [31:0] exp_r;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rem", rem_out, 32'h0);
    check("R1 done", {31'd0, done}, 32'h0);
    rst_n = 1'b1;

    // R2 seed masking
    seed(3'd2, 32'hDEADBEEF);
    check("R2 masked write", rem_out, 32'h0000BEEF);
    seed(3'd0, 32'hDEADBEEF);
    check("R2 full write", rem_out, 32'hDEADBEEF);

    // R3 check string, spans count 4 and count 1, R7
    seed(3'd0, 32'hFFFFFFFF);
    run(3'd0, 32'h31323334, 2'd0);
    run(3'd0, 32'h35363738, 2'd0);
    run(3'd0, 32'h39000000, 2'd1);
    check("R3 crc32 check", rem_out, 32'h0376E6E7);

    // R5 check string with counts 3,3,3 (R7)
    seed(3'd2, 32'h0);
    run(3'd2, 32'h31323300, 2'd3);
    run(3'd2, 32'h34353600, 2'd3);
    run(3'd2, 32'h37383900, 2'd3);
    check("R5 crc16 check", rem_out, 32'h0000FEE8);

    // R8 done timing and R9 hold
    seed(3'd1, 32'h12345678);
    @(negedge clk);
    start = 1'b1; mode = 3'd1; data = 32'hA5A5A5A5; nbytes = 2'd2;
    @(negedge clk);
    start = 1'b0;
    check("R8 done not early", {31'd0, done}, 32'h0);
    check("R8 rem not early", rem_out, 32'h12345678);
    @(negedge clk);
    exp_r = ref_crc(32'h12345678, 32'hA5A5A5A5, 2'd2, 3'd1);
    check("R8 done pulse", {31'd0, done}, 32'h1);
    check("R4 R8 crc32c update", rem_out, exp_r);
    @(negedge clk);
    check("R8 done one cycle", {31'd0, done}, 32'h0);
    data = 32'hFFFFFFFF; mode = 3'd4;
    repeat (4) @(negedge clk);
    check("R9 hold", rem_out, exp_r);

    // R10 back-to-back
    seed(3'd3, 32'h3FF);
    @(negedge clk);
    start = 1'b1; mode = 3'd3; data = 32'h11223344; nbytes = 2'd0;
    @(negedge clk);
    data = 32'hCAFEF00D; nbytes = 2'd2;
    @(negedge clk);
    start = 1'b0;
    exp_r = ref_crc(32'h3FF, 32'h11223344, 2'd0, 3'd3);
    check("R10 first", rem_out, exp_r);
    @(negedge clk);
    exp_r = ref_crc(exp_r, 32'hCAFEF00D, 2'd2, 3'd3);
    check("R10 second", rem_out, exp_r);
    check("R10 done second", {31'd0, done}, 32'h1);

    // R11 collision
    seed(3'd0, 32'h0BADF00D);
    @(negedge clk);
    start = 1'b1; mode = 3'd0; data = 32'h01020304; nbytes = 2'd0;
    @(negedge clk);
    start = 1'b0; wr_en = 1'b1; wr_data = 32'h55AA55AA;
    @(negedge clk);
    wr_en = 1'b0;
    check("R11 write wins", rem_out, 32'h55AA55AA);
    check("R11 done", {31'd0, done}, 32'h1);

    // R12 unused codes act as CRC-32
    seed(3'd6, 32'hFFFFFFFF);
    run(3'd6, 32'h31323334, 2'd0);
    run(3'd7, 32'h35363738, 2'd0);
    run(3'd5, 32'h39000000, 2'd1);
    check("R12 alias crc32", rem_out, 32'h0376E6E7);

    // R6 short CRCs, directed
    seed(3'd4, 32'hFFFFFFFF);
    check("R6 crc5 seed", rem_out, 32'h1F);
    run(3'd4, 32'hF0F0F0F0, 2'd0);
    check("R6 crc5 update", rem_out, ref_crc(32'h1F, 32'hF0F0F0F0, 2'd0, 3'd4));

    // random: R3 R4 R5 R6 R7 R12
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [2:0]  m = 3'($urandom_range(0, 7));
      logic [31:0] s = $urandom();
      logic [31:0] d = $urandom();
      logic [1:0]  nb = 2'($urandom_range(0, 3));
      seed(m, s);
      run(m, d, nb);
      exp_r = ref_crc(s & tb_mask(m), d, nb, m);
      case (m)
        3'd1:    check("R4 random", rem_out, exp_r);
        3'd2:    check("R5 R7 random", rem_out, exp_r);
        3'd3, 3'd4: check("R6 random", rem_out, exp_r);
        3'd0:    check("R3 R7 random", rem_out, exp_r);
        default: check("R12 random", rem_out, exp_r);
      endcase
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule